// File: doc/BRIEF.md
# Port-Limited Writeback Completion Pipeline

This block models the execute stage of an in-order core as a fixed-latency countdown. Each accepted issue carries a mask of destination registers. A fixed number of cycles after issue, the entry reaches the completion slot. There its registers are committed to the register file and reported to the scoreboard as retired. Data values and arithmetic are not modelled. Only the timing of register release is modelled.

The register file has a limited number of write ports, one by default. When the completion slot needs more writes than the ports allow in one cycle, the block retires as many registers as it can, lowest index first. It also raises a stall. While the stall is high the countdown freezes, so no entry moves and no new issue is accepted. The surplus drains over the next cycles. An external hold input freezes the countdown in the same way and also refuses issue. Retirement out of the completion slot goes on during a hold.

Top module: `wbp_top`

## Requirements
- R1: After reset, `retire_mask` is all zero, `wb_stall` is low and `issue_ready` is high.
- R2: An issue accepted at a clock edge, with `issue_valid` and `issue_ready` both high, reaches the completion slot after LAT (default 2) further edges. With the defaults, an issue driven in cycle t shows its registers on `retire_mask` in cycle t+2 and not in cycle t+1. Bit i of a mask stands for register i.
- R3: No more than PORTS (default 1) bits of `retire_mask` are set in any cycle. When the slot holds more registers than that, the lowest-indexed pending registers are retired first.
- R4: When the completion slot holds more than PORTS registers, `wb_stall` is high in that cycle. Each stalled cycle removes the retired registers from the slot. An entry with N registers and PORTS=1 retires over N consecutive cycles, and `wb_stall` is high in the first N-1 of them.
- R5: While `wb_stall` is high, no entry advances. Every younger entry completes exactly one cycle later for each stalled cycle.
- R6: `issue_ready` is low whenever `wb_stall` or `ext_hold` is high. An `issue_valid` presented while `issue_ready` is low is dropped: its registers never appear on `retire_mask`.
- R7: An entry with an all-zero mask uses no port. It never raises `wb_stall`, and it still takes one pipeline position, so the entry issued after it completes one cycle after it.
- R8: While `ext_hold` is high, entries do not advance, but the registers in the completion slot still retire under the port budget. A register that has retired is not reported again. Younger entries resume their countdown when the hold is released.
- R9: Entries issued on consecutive cycles with no stall complete on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; empties every slot |
| issue_valid | input | 1 | An instruction is offered for issue this cycle |
| issue_wmask | input | NREGS | Destination registers of the offered instruction |
| ext_hold | input | 1 | External freeze of the countdown; also refuses issue |
| issue_ready | output | 1 | Issue is accepted at the next edge when high |
| retire_mask | output | NREGS | Registers committed this cycle, reported to the scoreboard |
| wb_stall | output | 1 | Completion slot needs more writes than the ports allow |

## Verification
A countdown that moves during a stall or a hold shows up at the ports within one cycle after the freeze ends. A younger entry then appears on `retire_mask` a cycle early. A completion slot that is not cleaned up after each write reports the same register twice on consecutive cycles, or keeps `wb_stall` high one cycle too long. A refused issue that still gets into the pipeline produces a stray retire bit two cycles after it was offered. Each of these faults shows up at the ports within a few cycles of the stimulus that provokes it.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

    localparam int unsigned WBP_NREGS_DEF = 16;
    localparam int unsigned WBP_LAT_DEF   = 2;
    localparam int unsigned WBP_PORTS_DEF = 1;

    typedef enum logic [1:0] {
        MOVE_RUN   = 2'd0,
        MOVE_PORTS = 2'd1,
        MOVE_HOLD  = 2'd2
    } move_e;

endpackage

// File: rtl/wbp_port_pick.sv
module wbp_port_pick #(
    parameter int unsigned NREGS = 16,
    parameter int unsigned PORTS = 1
) (
    input  logic [NREGS-1:0] pending,
    output logic [NREGS-1:0] grant,
    output logic [NREGS-1:0] left,
    output logic             overflow
);
    localparam int unsigned CW = $clog2(NREGS + 1);

    logic [CW-1:0] used;

    // Walk from register 0 upward, granting until the port budget is spent.
    always_comb begin
        used  = '0;
        grant = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (pending[i] && (used < CW'(PORTS))) begin
                grant[i] = 1'b1;
                used     = used + CW'(1);
            end
        end
    end

    assign left     = pending & ~grant;
    assign overflow = |left;

endmodule

// File: rtl/wbp_countdown.sv
module wbp_countdown #(
    parameter int unsigned NREGS = 16,
    parameter int unsigned LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wbp_pkg::move_e   move,
    input  logic             load_en,
    input  logic [NREGS-1:0] load_mask,
    input  logic [NREGS-1:0] head_left,
    output logic [NREGS-1:0] head_mask
);
    import wbp_pkg::*;

    typedef struct packed {
        logic [LAT-1:0][NREGS-1:0] slot;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (move == MOVE_RUN) begin
            for (int i = 0; i < LAT - 1; i++) begin
                st_d.slot[i] = st_q.slot[i+1];
            end
            st_d.slot[LAT-1] = load_en ? load_mask : '0;
        end else begin
            // Frozen: only the completion slot sheds what it wrote.
            st_d.slot[0] = head_left;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_mask = st_q.slot[0];

    // R5 / R8: every entry behind the completion slot keeps its place while frozen.
    for (genvar g = 1; g < LAT; g++) begin : g_hold_chk
        a_r5_young_frozen: assert property (
            @(posedge clk) disable iff (!rst_n)
            (move != MOVE_RUN) |=> $stable(st_q.slot[g])
        );
    end

    // R6: nothing is loaded into a frozen pipeline.
    a_r6_no_load_frozen: assert property (
        @(posedge clk) disable iff (!rst_n)
        (move != MOVE_RUN) |-> !load_en
    );

endmodule

// File: rtl/wbp_top.sv
module wbp_top #(
    parameter int unsigned NREGS = wbp_pkg::WBP_NREGS_DEF,
    parameter int unsigned LAT   = wbp_pkg::WBP_LAT_DEF,
    parameter int unsigned PORTS = wbp_pkg::WBP_PORTS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [NREGS-1:0] issue_wmask,
    input  logic             ext_hold,
    output logic             issue_ready,
    output logic [NREGS-1:0] retire_mask,
    output logic             wb_stall
);
    import wbp_pkg::*;

    logic [NREGS-1:0] head_mask;
    logic [NREGS-1:0] head_left;
    logic             port_over;
    move_e            move;

    wbp_port_pick #(.NREGS(NREGS), .PORTS(PORTS)) u_pick (
        .pending  (head_mask),
        .grant    (retire_mask),
        .left     (head_left),
        .overflow (port_over)
    );

    always_comb begin
        if (port_over)     move = MOVE_PORTS;
        else if (ext_hold) move = MOVE_HOLD;
        else               move = MOVE_RUN;
    end

    assign wb_stall    = port_over;
    assign issue_ready = (move == MOVE_RUN);

    wbp_countdown #(.NREGS(NREGS), .LAT(LAT)) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .move      (move),
        .load_en   (issue_valid && issue_ready),
        .load_mask (issue_wmask),
        .head_left (head_left),
        .head_mask (head_mask)
    );

    // R3: the write-port budget is never exceeded.
    a_r3_port_budget: assert property (
        @(posedge clk) disable iff (!rst_n)
        $countones(retire_mask) <= PORTS
    );

    // R3: no register still waiting sits below the lowest one written.
    a_r3_lowest_first: assert property (
        @(posedge clk) disable iff (!rst_n)
        ((head_left & (retire_mask - 1'b1)) == '0)
    );

    // R4: a stall cycle always uses the full budget, and draining goes on next cycle.
    a_r4_full_ports: assert property (
        @(posedge clk) disable iff (!rst_n)
        wb_stall |-> ($countones(retire_mask) == PORTS)
    );
    a_r4_drain_continues: assert property (
        @(posedge clk) disable iff (!rst_n)
        wb_stall |=> (retire_mask != '0)
    );

    // R6: issue is refused during stall or hold.
    a_r6_ready_low: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wb_stall || ext_hold) |-> !issue_ready
    );

    // R8: a frozen completion slot never reports the same register twice.
    a_r8_no_repeat: assert property (
        @(posedge clk) disable iff (!rst_n)
        !issue_ready |=> ((retire_mask & $past(retire_mask)) == '0)
    );

endmodule

// File: tb/tb_wbp_top.sv
module tb_wbp_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREGS = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             issue_valid;
    logic [NREGS-1:0] issue_wmask;
    logic             ext_hold;
    logic             issue_ready;
    logic [NREGS-1:0] retire_mask;
    logic             wb_stall;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wbp_top #(.NREGS(NREGS), .LAT(2), .PORTS(1)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_wmask (issue_wmask),
        .ext_hold    (ext_hold),
        .issue_ready (issue_ready),
        .retire_mask (retire_mask),
        .wb_stall    (wb_stall)
    );

    task automatic chk(input string tag, input logic [NREGS-1:0] act, input logic [NREGS-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic offer(input logic v, input logic [NREGS-1:0] m);
        issue_valid = v;
        issue_wmask = m;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 retire after reset", retire_mask, '0);
        chk1("R1 stall after reset", wb_stall, 1'b0);
        chk1("R1 ready after reset", issue_ready, 1'b1);
    endtask

    task automatic t_latency();
        offer(1'b1, 16'h0010);
        cyc(); offer(1'b0, '0);
        chk("R2 not yet complete", retire_mask, '0);
        cyc();
        chk("R2 complete after two edges", retire_mask, 16'h0010);
        chk1("R4 single write no stall", wb_stall, 1'b0);
        cyc();
        chk("R2 slot empty afterwards", retire_mask, '0);
        repeat (2) cyc();
    endtask

    task automatic t_drain();
        offer(1'b1, 16'h0106);
        cyc(); offer(1'b0, '0);
        cyc();
        chk("R3 lowest first", retire_mask, 16'h0002);
        chk1("R4 stall on surplus", wb_stall, 1'b1);
        chk1("R6 ready low in stall", issue_ready, 1'b0);
        cyc();
        chk("R3 second register", retire_mask, 16'h0004);
        chk1("R4 stall continues", wb_stall, 1'b1);
        cyc();
        chk("R3 last register", retire_mask, 16'h0100);
        chk1("R4 stall clears on last", wb_stall, 1'b0);
        chk1("R6 ready back", issue_ready, 1'b1);
        cyc();
        chk("R4 drained", retire_mask, '0);
        repeat (2) cyc();
    endtask

    task automatic t_freeze();
        offer(1'b1, 16'h000C);
        cyc(); offer(1'b1, 16'h0020);
        cyc(); offer(1'b1, 16'h0001);
        chk("R5 head first write", retire_mask, 16'h0004);
        chk1("R5 stall", wb_stall, 1'b1);
        cyc(); offer(1'b0, '0);
        chk("R5 young not advanced", retire_mask, 16'h0008);
        chk1("R4 stall cleared", wb_stall, 1'b0);
        cyc();
        chk("R5 young delayed one cycle", retire_mask, 16'h0020);
        cyc();
        chk("R6 refused issue dropped", retire_mask, '0);
        cyc();
        chk("R6 refused issue never retires", retire_mask, '0);
        repeat (2) cyc();
    endtask

    task automatic t_empty();
        offer(1'b1, 16'h0000);
        cyc(); offer(1'b1, 16'h0040);
        cyc(); offer(1'b0, '0);
        chk("R7 empty entry writes nothing", retire_mask, '0);
        chk1("R7 empty entry no stall", wb_stall, 1'b0);
        chk1("R7 ready kept", issue_ready, 1'b1);
        cyc();
        chk("R7 follower one cycle later", retire_mask, 16'h0040);
        repeat (2) cyc();
    endtask

    task automatic t_b2b();
        offer(1'b1, 16'h0001);
        cyc(); offer(1'b1, 16'h0002);
        cyc(); offer(1'b1, 16'h0004);
        chk("R9 first", retire_mask, 16'h0001);
        cyc(); offer(1'b0, '0);
        chk("R9 second", retire_mask, 16'h0002);
        cyc();
        chk("R9 third", retire_mask, 16'h0004);
        repeat (2) cyc();
    endtask

    task automatic t_hold();
        offer(1'b1, 16'h0003);
        cyc(); offer(1'b1, 16'h0400);
        cyc(); offer(1'b1, 16'h0080); ext_hold = 1'b1;
        #1;
        chk("R8 head retires under hold", retire_mask, 16'h0001);
        chk1("R8 stall", wb_stall, 1'b1);
        chk1("R6 ready low", issue_ready, 1'b0);
        cyc();
        chk("R8 second write under hold", retire_mask, 16'h0002);
        chk1("R8 no port stall", wb_stall, 1'b0);
        chk1("R6 ready low in hold", issue_ready, 1'b0);
        cyc();
        chk("R8 no repeat retire", retire_mask, '0);
        chk1("R6 ready still low", issue_ready, 1'b0);
        ext_hold = 1'b0; offer(1'b0, '0);
        cyc();
        chk("R8 young resumes after hold", retire_mask, 16'h0400);
        cyc();
        chk("R6 issue in hold dropped", retire_mask, '0);
        repeat (2) cyc();
    endtask

    initial begin
        rst_n = 1'b0;
        ext_hold = 1'b0;
        offer(1'b0, '0);
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_latency();
        t_drain();
        t_freeze();
        t_empty();
        t_b2b();
        t_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule